// File: doc/BRIEF.md
# Four-Tributary Second-Level Frame Multiplexer

The block combines four primary-rate serial tributaries into one second-level serial stream, one output bit per clock. Each tributary writes bits, with a write strobe, into its own small elastic buffer. The output side walks a fixed 1176-bit frame of four subframes. Each subframe holds six blocks, and each block is one control bit followed by 48 payload bits. In the payload, the four tributaries take turns bit by bit.

The tributaries run slightly slower than their share of the output rate. To absorb the difference, each subframe has one stuff opportunity for one tributary. When that tributary's buffer is less than half full, the slot carries a filler 0 and nothing is read from the buffer. The first control bit of each subframe forms a frame-identification pattern, and the last of these four bits carries an alarm flag.

Top module: `ds2_frame_mux`

## Requirements
- R1: While `rst` is high, and after the first clock edge that samples it high, `out_bit` and `out_sof` are 0. The next frame starts at its first bit, and all four buffers are empty.
- R2: The frame is 1176 output bits, one per clock. `out_sof` is 1 exactly on the first bit of each frame. A slot's bit appears at the outputs one clock after the edge that processes the slot.
- R3: Bit 0 of each subframe (frame positions 0, 294, 588, 882) is an M bit. The M bits of subframes 0, 1 and 2 are 0, 1 and 1.
- R4: The M bit of subframe 3 is 1 when `alarm` is 0 and 0 when `alarm` is 1, with `alarm` sampled in that slot's cycle.
- R5: Every other block-leading control bit (blocks 1 to 5 of each subframe, block position 0) is sent as 0.
- R6: Block position j (1 to 48) carries tributary (j-1) mod 4. Each tributary's bits leave in the order they were written.
- R7: In subframe k, block 5, position k+1 is tributary k's stuff opportunity. If that buffer's fill level before the edge is below 4, the slot sends 0 and pops nothing. Otherwise it carries data as in R6.
- R8: A payload slot whose tributary buffer is empty sends 0 and pops nothing.
- R9: Each buffer holds 8 bits. A write to a full buffer is dropped unless the same edge also pops that buffer, in which case the write is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output bit clock |
| rst | input | 1 | Synchronous active-high reset |
| trib_wr | input | 4 | Per-tributary write strobe |
| trib_bit | input | 4 | Per-tributary data bit, taken when its strobe is high |
| alarm | input | 1 | Alarm flag, sent inverted in the last M bit |
| out_bit | output | 1 | Registered serial frame output |
| out_sof | output | 1 | Registered marker on the first bit of each frame |

## Verification
The assertions check, on every cycle, these structural facts:
- the frame position counter stays in range and wraps as expected;
- no buffer is popped while empty or grows beyond its depth;
- at most one buffer is popped per slot, and a stuffed slot never pops;
- the frame marker always coincides with a 0 M bit.

Only the bench scenarios can show that the right data bits arrive in the right slots and in write order. The same holds for the M and alarm patterns and for the stuff decision at each opportunity as buffer fill levels change. These scenarios include a starving tributary, a saturating tributary that forces dropped writes, and a reset in mid-frame.

// File: rtl/ds2_mux_pkg.sv
package ds2_mux_pkg;
  localparam int DEF_NUM_TRIB   = 4;
  localparam int DEF_ROUNDS     = 12;
  localparam int DEF_NUM_BLK    = 6;
  localparam int DEF_FIFO_DEPTH = 8;

  typedef enum logic [2:0] {
    SLOT_MBIT,
    SLOT_CTRL,
    SLOT_STUFF,
    SLOT_IDLE,
    SLOT_DATA
  } slot_e;
endpackage

// File: rtl/ds2_frame_counter.sv
module ds2_frame_counter #(
  parameter int SF_N   = 4,
  parameter int BLK_N  = 6,
  parameter int BITS_N = 49,
  localparam int SF_W  = $clog2(SF_N),
  localparam int BLK_W = $clog2(BLK_N),
  localparam int POS_W = $clog2(BITS_N)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [SF_W-1:0]  sf,
  output logic [BLK_W-1:0] blk,
  output logic [POS_W-1:0] pos
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sf  <= '0;
      blk <= '0;
      pos <= '0;
    end else if (int'(pos) == BITS_N - 1) begin
      pos <= '0;
      if (int'(blk) == BLK_N - 1) begin
        blk <= '0;
        sf  <= (int'(sf) == SF_N - 1) ? '0 : sf + SF_W'(1);
      end else begin
        blk <= blk + BLK_W'(1);
      end
    end else begin
      pos <= pos + POS_W'(1);
    end
  end

  // R2: the slot position never leaves the block
  p_pos_range_r2: assert property (@(posedge clk) disable iff (rst)
    int'(pos) < BITS_N && int'(blk) < BLK_N);

  // R2: the last block position is followed by position 0
  p_pos_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(pos) == BITS_N - 1) |=> (pos == '0));
endmodule

// File: rtl/ds2_trib_fifo.sv
module ds2_trib_fifo #(
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             wr_bit,
  input  logic             rd,
  output logic             rd_bit,
  output logic [LVL_W-1:0] level
);
  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok;

  assign push_ok = wr && ((int'(level) < DEPTH) || rd);
  assign rd_bit  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (rd)      rd_ptr <= rd_ptr + AW'(1);
      case ({push_ok, rd})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  // R9: fill never exceeds depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= DEPTH);

  // R8: the frame side never pops an empty buffer
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    rd |-> (level != '0));
endmodule

// File: rtl/ds2_frame_mux.sv
module ds2_frame_mux
  import ds2_mux_pkg::*;
#(
  parameter int NUM_TRIB   = DEF_NUM_TRIB,
  parameter int ROUNDS     = DEF_ROUNDS,
  parameter int NUM_BLK    = DEF_NUM_BLK,
  parameter int FIFO_DEPTH = DEF_FIFO_DEPTH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TRIB-1:0] trib_wr,
  input  logic [NUM_TRIB-1:0] trib_bit,
  input  logic                alarm,
  output logic                out_bit,
  output logic                out_sof
);
  localparam int NUM_SF   = NUM_TRIB;
  localparam int BLK_BITS = 1 + NUM_TRIB * ROUNDS;
  localparam int SF_W     = $clog2(NUM_SF);
  localparam int BLK_W    = $clog2(NUM_BLK);
  localparam int POS_W    = $clog2(BLK_BITS);
  localparam int TRIB_W   = $clog2(NUM_TRIB);
  localparam int LVL_W    = $clog2(FIFO_DEPTH + 1);
  localparam int LOW_MARK = FIFO_DEPTH / 2;

  logic [SF_W-1:0]     sf;
  logic [BLK_W-1:0]    blk;
  logic [POS_W-1:0]    pos;
  logic [TRIB_W-1:0]   trib_sel;
  logic [NUM_TRIB-1:0] pop;
  logic [NUM_TRIB-1:0] rd_bits;
  logic [LVL_W-1:0]    level [NUM_TRIB];
  logic                stuff_pos;
  logic                m_value;
  logic                nxt_bit;
  slot_e               slot_kind;

  ds2_frame_counter #(
    .SF_N  (NUM_SF),
    .BLK_N (NUM_BLK),
    .BITS_N(BLK_BITS)
  ) u_cnt (
    .clk(clk),
    .rst(rst),
    .sf (sf),
    .blk(blk),
    .pos(pos)
  );

  for (genvar g = 0; g < NUM_TRIB; g++) begin : g_fifo
    ds2_trib_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .wr    (trib_wr[g]),
      .wr_bit(trib_bit[g]),
      .rd    (pop[g]),
      .rd_bit(rd_bits[g]),
      .level (level[g])
    );
  end

  assign trib_sel  = TRIB_W'(int'(pos) - 1);
  assign stuff_pos = (int'(blk) == NUM_BLK - 1) && (int'(pos) == int'(sf) + 1);

  // Classify the current slot
  always_comb begin
    if (pos == '0) begin
      slot_kind = (blk == '0) ? SLOT_MBIT : SLOT_CTRL;
    end else if (stuff_pos && int'(level[trib_sel]) < LOW_MARK) begin
      slot_kind = SLOT_STUFF;
    end else if (level[trib_sel] == '0) begin
      slot_kind = SLOT_IDLE;
    end else begin
      slot_kind = SLOT_DATA;
    end
  end

  // M pattern: first subframe 0, last carries inverted alarm, others 1
  always_comb begin
    if (sf == '0)                  m_value = 1'b0;
    else if (int'(sf) == NUM_SF-1) m_value = ~alarm;
    else                           m_value = 1'b1;
  end

  always_comb begin
    pop     = '0;
    nxt_bit = 1'b0;
    case (slot_kind)
      SLOT_MBIT: nxt_bit = m_value;
      SLOT_DATA: begin
        nxt_bit       = rd_bits[trib_sel];
        pop[trib_sel] = 1'b1;
      end
      default:   nxt_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_bit <= 1'b0;
      out_sof <= 1'b0;
    end else begin
      out_bit <= nxt_bit;
      out_sof <= (sf == '0) && (blk == '0) && (pos == '0);
    end
  end

  // R7: a stuffed slot reads nothing
  p_stuff_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (slot_kind == SLOT_STUFF) |-> (pop == '0));

  // R6: one tributary at most is served per slot
  p_single_pop_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop));

  // R3: the frame marker coincides with the 0 M bit
  p_sof_mbit_r3: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> !out_bit);
endmodule

// File: tb/ds2_frame_mux_tb.sv
module ds2_frame_mux_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT         = 4;
  localparam int BLK_BITS   = 49;
  localparam int NBLK       = 6;
  localparam int NSF        = 4;
  localparam int DEPTH      = 8;
  localparam int FRAME      = 1176;
  localparam int WD_CYCLES  = 60000;

  typedef struct packed {
    logic       alm;
    logic [9:0] r0;
    logic [9:0] r1;
    logic [9:0] r2;
    logic [9:0] r3;
    logic       exp_x;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 10'd245, 10'd245, 10'd245, 10'd245, 1'b1},
    '{1'b1, 10'd240, 10'd250, 10'd230, 10'd260, 1'b0},
    '{1'b0, 10'd0,   10'd300, 10'd245, 10'd200, 1'b1},
    '{1'b1, 10'd999, 10'd0,   10'd500, 10'd245, 1'b0},
    '{1'b0, 10'd244, 10'd246, 10'd248, 10'd242, 1'b1},
    '{1'b1, 10'd245, 10'd245, 10'd245, 10'd245, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NT-1:0] trib_wr = '0;
  logic [NT-1:0] trib_bit = '0;
  logic          alarm = 1'b0;
  logic          out_bit, out_sof;

  int   checks = 0, failures = 0;
  bit   done = 1'b0;
  int   mpos, mblk, msf;
  int   qcnt [NT];
  int   qrd  [NT];
  logic qmem [NT][DEPTH];
  int   acc  [NT];
  int   cur_rate [NT];
  logic cur_alarm, cur_xexp;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ds2_frame_mux u_dut (
    .clk(clk), .rst(rst), .trib_wr(trib_wr), .trib_bit(trib_bit),
    .alarm(alarm), .out_bit(out_bit), .out_sof(out_sof)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    mpos = 0; mblk = 0; msf = 0;
    for (int t = 0; t < NT; t++) begin
      qcnt[t] = 0; qrd[t] = 0; acc[t] = 0;
    end
  endtask

  // One slot: drive at negedge, predict, clock, compare at next negedge
  task automatic step(input string scen);
    logic e_bit, e_sof;
    string tag;
    int t, pop_idx, wr_idx;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    for (int i = 0; i < NT; i++) begin
      acc[i] += cur_rate[i];
      if (acc[i] >= 1000) begin acc[i] -= 1000; trib_wr[i] = 1'b1; end
      else trib_wr[i] = 1'b0;
      trib_bit[i] = lfsr[i*3];
    end
    alarm = cur_alarm;
    pop_idx = -1;
    e_bit = 1'b0;
    e_sof = (mpos == 0 && mblk == 0 && msf == 0);
    if (mpos == 0 && mblk == 0) begin
      if (msf == NSF-1) begin tag = "R4"; e_bit = cur_xexp; end
      else begin tag = "R3"; e_bit = (msf != 0); end
    end else if (mpos == 0) begin
      tag = "R5";
    end else begin
      t = (mpos - 1) % NT;
      if (mblk == NBLK-1 && mpos == msf + 1 && qcnt[t] < DEPTH/2) tag = "R7";
      else if (qcnt[t] == 0) tag = "R8";
      else begin tag = "R6"; e_bit = qmem[t][qrd[t]]; pop_idx = t; end
    end
    for (int i = 0; i < NT; i++) begin
      wr_idx = (qrd[i] + qcnt[i]) % DEPTH;
      if (pop_idx == i) begin qrd[i] = (qrd[i] + 1) % DEPTH; qcnt[i]--; end
      if (trib_wr[i] && qcnt[i] < DEPTH) begin qmem[i][wr_idx] = trib_bit[i]; qcnt[i]++; end
    end
    mpos++;
    if (mpos == BLK_BITS) begin
      mpos = 0; mblk++;
      if (mblk == NBLK) begin mblk = 0; msf = (msf + 1) % NSF; end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, out_bit, e_bit, scen);
    check("R2", out_sof, e_sof, scen);
  endtask

  task automatic set_rates(input int a, input int b, input int c, input int d);
    cur_rate[0] = a; cur_rate[1] = b; cur_rate[2] = c; cur_rate[3] = d;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    set_rates(0, 0, 0, 0);
    cur_alarm = 1'b0; cur_xexp = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", out_bit, 1'b0, "reset out_bit");
    check("R1", out_sof, 1'b0, "reset out_sof");
    rst = 1'b0;

    // Table walk: one frame per vector, stream continues across vectors
    for (int v = 0; v < NVEC; v++) begin
      set_rates(int'(VEC[v].r0), int'(VEC[v].r1), int'(VEC[v].r2), int'(VEC[v].r3));
      cur_alarm = VEC[v].alm;
      cur_xexp  = VEC[v].exp_x;
      repeat (FRAME) step($sformatf("table vector %0d", v));
    end

    // R9: all tributaries saturate, forcing dropped writes, then drain
    set_rates(999, 999, 999, 999);
    cur_alarm = 1'b0; cur_xexp = 1'b1;
    repeat (FRAME) step("R9 saturate");
    set_rates(0, 0, 0, 0);
    repeat (300) step("R9 drain");

    // R1: reset in mid-frame with full buffers
    set_rates(999, 999, 999, 999);
    repeat (100) step("R1 prefill");
    rst = 1'b1;
    trib_wr = '0;
    @(posedge clk);
    @(negedge clk);
    check("R1", out_bit, 1'b0, "mid-run reset out_bit");
    check("R1", out_sof, 1'b0, "mid-run reset out_sof");
    rst = 1'b0;
    model_reset();
    set_rates(0, 0, 0, 0);
    cur_alarm = 1'b1; cur_xexp = 1'b0;
    repeat (FRAME + 2) step("R1 after reset, buffers empty");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule